// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is the multiplier of a 32-bit integer execute stage, merged with a 64-bit running-sum register. Each request carries two 32-bit operands, a 3-bit operation code and a valid strobe. It asks for either the low or the high word of a signed, unsigned or mixed-sign product. Plain multiply requests load the running sum with the full product. Accumulate requests add the product into the running sum. In both cases the requested word of the running sum is returned.

The product is formed from four half-width partial products, and their summation is split into three pipelined parts. The low result word appears one cycle after issue, with the carry out of the low half held for one register stage. The high word appears one cycle later. A new request may issue in every cycle. Each result word has its own output bus and its own valid bit, so a low result and an earlier high result can arrive in the same cycle.

Top module: `mac_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears the 64-bit running sum and both result valid bits, so `out_valid` reads 2'b00 in the cycle after reset is seen.
- R2: `req_op[2]` selects accumulate (1) or load (0). `req_op[1:0]` selects the result word and signedness: 2'b00 low word (signed by signed), 2'b01 high word signed by signed, 2'b10 high word signed `req_a` by unsigned `req_b`, 2'b11 high word unsigned by unsigned.
- R3: A request with `req_op[2]`=0 replaces the running sum with the full 64-bit product. The returned word is the matching word of that product.
- R4: A request with `req_op[2]`=1 sets the running sum to the old sum plus the 64-bit product. The returned word is the matching word of the new sum.
- R5: For a low-word request, `out_valid[0]` is high and `res_lo` holds the result exactly one cycle after the request is accepted. `out_valid[1]` stays low for that request.
- R6: For a high-word request, `out_valid[1]` is high and `res_hi` holds the result exactly two cycles after issue. Neither valid bit rises for it one cycle after issue.
- R7: For accumulation, operands are sign- or zero-extended to 64 bits as the code in R2 gives, so negative operands contribute negative products.
- R8: Requests on consecutive cycles each see the running sum left by the request before them. A low result and an older high result may be valid in the same cycle.
- R9: Cycles with `req_valid` low leave the running sum unchanged, whatever the operands carry.
- R10: The running sum wraps modulo 2^64 on overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 3 | {accumulate, word/signedness code} |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand |
| out_valid | output | 2 | Bit 0: low word ready; bit 1: high word ready |
| res_lo | output | 32 | Low word of the running sum |
| res_hi | output | 32 | High word of the running sum |

## Verification
A vector table walks every operation code with small positive values, all-ones, the most negative value and mixed patterns. These vectors separate the signed, mixed and unsigned extensions, and loading from accumulating. An unsigned all-ones pair accumulated twice forces the 64-bit sum to wrap. A directed burst of three back-to-back requests shows the chained running sum and the coincident low and high valid bits. Idle cycles with changing operands, and a reset in the middle of the run, are then read back through zero-product accumulate requests.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    PART_LO    = 2'b00,
    PART_HI_SS = 2'b01,
    PART_HI_SU = 2'b10,
    PART_HI_UU = 2'b11
  } part_e;

  typedef struct packed {
    logic  accum;
    part_e part;
  } mac_op_t;
endpackage

// File: rtl/mac_partial.sv
module mac_partial #(
  parameter int W = 32
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic               a_signed,
  input  logic               b_signed,
  output logic [W-1:0]       lo_word,
  output logic               lo_carry,
  output logic [W/2+2:0]     mid_up,
  output logic [W-1:0]       hh_lo
);
  localparam int H  = W / 2;
  localparam int PW = W + 2;
  localparam int MW = W + 3;

  logic signed [H:0]    ah, bh, al, bl;
  logic signed [PW-1:0] pp_lh, pp_hl;
  logic signed [MW-1:0] mid;
  logic [W-1:0]         pp_ll;
  logic [W:0]           sum_lo;

  assign ah = {a_signed & a[W-1], a[W-1:H]};
  assign bh = {b_signed & b[W-1], b[W-1:H]};
  assign al = {1'b0, a[H-1:0]};
  assign bl = {1'b0, b[H-1:0]};

  // part one: low-by-low, cross terms, high-by-high
  assign pp_ll = W'(a[H-1:0]) * W'(b[H-1:0]);
  assign pp_lh = PW'(al) * PW'(bh);
  assign pp_hl = PW'(ah) * PW'(bl);
  assign mid   = MW'(pp_lh) + MW'(pp_hl);
  assign hh_lo = W'(ah) * W'(bh);

  // part two: low word with carry kept for the next stage
  assign sum_lo   = {1'b0, pp_ll} + {1'b0, mid[H-1:0], {H{1'b0}}};
  assign lo_word  = sum_lo[W-1:0];
  assign lo_carry = sum_lo[W];
  assign mid_up   = mid[MW-1:H];
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           accum,
  input  logic           want_lo,
  input  logic           want_hi,
  input  logic [W-1:0]   lo_word,
  input  logic           lo_carry,
  input  logic [W/2+2:0] mid_up,
  input  logic [W-1:0]   hh_lo,
  output logic [W-1:0]   acc_lo,
  output logic [W-1:0]   acc_hi,
  output logic           vld_lo,
  output logic           vld_hi
);
  localparam int H  = W / 2;
  localparam int UW = H + 3;

  logic [W-1:0]  base_lo, base_hi, mid_ext;
  logic [W:0]    acc_sum;
  logic          s1_v, s1_acc, s1_hi;
  logic [1:0]    s1_cin;
  logic [UW-1:0] s1_mid_up;
  logic [W-1:0]  s1_hh;

  assign base_lo = accum ? acc_lo : '0;
  assign acc_sum = {1'b0, base_lo} + {1'b0, lo_word};
  assign base_hi = s1_acc ? acc_hi : '0;
  assign mid_ext = {{(W-UW){s1_mid_up[UW-1]}}, s1_mid_up};

  // stage one: low half of the running sum
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_lo    <= '0;
      vld_lo    <= 1'b0;
      s1_v      <= 1'b0;
      s1_acc    <= 1'b0;
      s1_hi     <= 1'b0;
      s1_cin    <= '0;
      s1_mid_up <= '0;
      s1_hh     <= '0;
    end else begin
      vld_lo    <= in_valid & want_lo;
      s1_v      <= in_valid;
      s1_acc    <= accum;
      s1_hi     <= want_hi;
      s1_cin    <= {1'b0, lo_carry} + {1'b0, acc_sum[W]};
      s1_mid_up <= mid_up;
      s1_hh     <= hh_lo;
      if (in_valid) acc_lo <= acc_sum[W-1:0];
    end
  end

  // stage two: high half of the running sum
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi <= '0;
      vld_hi <= 1'b0;
    end else begin
      vld_hi <= s1_v & s1_hi;
      if (s1_v) acc_hi <= base_hi + s1_hh + mid_ext + W'(s1_cin);
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_lo == '0 && acc_hi == '0 && !vld_lo && !vld_hi));
  // R5
  lo_latency_chk: assert property (@(posedge clk) disable iff (rst)
    vld_lo |-> $past(in_valid));
  // R6
  hi_latency_chk: assert property (@(posedge clk) disable iff (rst)
    vld_hi |-> $past(in_valid, 2));
  // R9
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc_lo));
  // R9
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> $stable(acc_hi));
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [2:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic [1:0]   out_valid,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam int H = W / 2;

  mac_op_t        op;
  logic           a_signed, b_signed, want_lo;
  logic [W-1:0]   lo_word, hh_lo;
  logic           lo_carry;
  logic [H+2:0]   mid_up;
  logic           vld_lo, vld_hi;

  assign op       = mac_op_t'(req_op);
  assign a_signed = (op.part != PART_HI_UU);
  assign b_signed = (op.part == PART_LO) || (op.part == PART_HI_SS);
  assign want_lo  = (op.part == PART_LO);

  mac_partial #(.W(W)) u_part (
    .a        (req_a),
    .b        (req_b),
    .a_signed (a_signed),
    .b_signed (b_signed),
    .lo_word  (lo_word),
    .lo_carry (lo_carry),
    .mid_up   (mid_up),
    .hh_lo    (hh_lo)
  );

  mac_accum #(.W(W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .accum    (op.accum),
    .want_lo  (want_lo),
    .want_hi  (!want_lo),
    .lo_word  (lo_word),
    .lo_carry (lo_carry),
    .mid_up   (mid_up),
    .hh_lo    (hh_lo),
    .acc_lo   (res_lo),
    .acc_hi   (res_hi),
    .vld_lo   (vld_lo),
    .vld_hi   (vld_hi)
  );

  assign out_valid = {vld_hi, vld_lo};
endmodule

// File: tb/sim_mac_pipe.sv
module sim_mac_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_a = '0, req_b = '0;
  logic [1:0]  out_valid;
  logic [31:0] res_lo, res_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] macc = '0;

  mac_pipe u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
               .req_a(req_a), .req_b(req_b), .out_valid(out_valid),
               .res_lo(res_lo), .res_hi(res_hi));

  initial forever #2.5ns clk = ~clk;

  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {3'b000, 32'd7,        32'd6},
    {3'b100, 32'hFFFFFFFF, 32'd3},
    {3'b101, 32'd0,        32'd0},
    {3'b001, 32'h80000000, 32'h80000000},
    {3'b110, 32'hFFFFFFFF, 32'd2},
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {3'b111, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {3'b010, 32'h80000000, 32'hFFFFFFFF},
    {3'b100, 32'h12345678, 32'h9ABCDEF0},
    {3'b001, 32'h7FFFFFFF, 32'h80000000},
    {3'b101, 32'hDEADBEEF, 32'h0BADF00D},
    {3'b000, 32'd0,        32'd0}
  };

  function automatic logic [63:0] pmodel(input logic [1:0] k, input logic [31:0] a, b);
    logic [63:0] xa, xb;
    xa = (k != 2'b11) ? {{32{a[31]}}, a} : {32'b0, a};
    xb = (k == 2'b00 || k == 2'b01) ? {{32{b[31]}}, b} : {32'b0, b};
    return xa * xb;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_issue(input logic [2:0] op, input logic [31:0] a, b);
    logic [63:0] p;
    p = pmodel(op[1:0], a, b);
    macc = op[2] ? macc + p : p;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [31:0] a, b, input string tag);
    logic [63:0] exp_sum;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    model_issue(op, a, b);
    exp_sum = macc;
    @(negedge clk);
    req_valid = 1'b0; req_a = ~a; req_b = ~b;
    if (op[1:0] == 2'b00) begin
      check({tag, " R5 low valid"}, 64'(out_valid), 64'd1);
      check({tag, " low word"}, 64'(res_lo), 64'(exp_sum[31:0]));
      @(negedge clk);
    end else begin
      check({tag, " R6 no early valid"}, 64'(out_valid), 64'd0);
      @(negedge clk);
      check({tag, " R6 high valid"}, 64'(out_valid), 64'd2);
      check({tag, " high word"}, 64'(res_hi), 64'(exp_sum[63:32]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset sum", {res_hi, res_lo}, 64'd0);
    rst = 1'b0;

    // table walk: R2 encoding, R3 load, R4 accumulate, R7 signedness, R10 wrap (entry 6)
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      string tag;
      op = VEC[i][66:64];
      tag = op[2] ? "R2 R4" : "R2 R3";
      if (op[1:0] != 2'b00) tag = {tag, " R7"};
      if (i == 6) tag = {tag, " R10"};
      do_op(op, VEC[i][63:32], VEC[i][31:0], tag);
    end

    // R8: back-to-back requests chaining through the running sum
    begin
      logic [63:0] sa, sb, sc;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'b001; req_a = 32'hFFFF0000; req_b = 32'h00012345;
      model_issue(req_op, req_a, req_b); sa = macc;
      @(negedge clk);
      check("R8 cycle1 valid", 64'(out_valid), 64'd0);
      req_op = 3'b100; req_a = 32'h0000ABCD; req_b = 32'hFFFFFFF0;
      model_issue(req_op, req_a, req_b); sb = macc;
      @(negedge clk);
      check("R8 cycle2 valid", 64'(out_valid), 64'd3);
      check("R8 cycle2 high", 64'(res_hi), 64'(sa[63:32]));
      check("R8 cycle2 low", 64'(res_lo), 64'(sb[31:0]));
      req_op = 3'b111; req_a = 32'h87654321; req_b = 32'h0FEDCBA9;
      model_issue(req_op, req_a, req_b); sc = macc;
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 cycle3 valid", 64'(out_valid), 64'd0);
      @(negedge clk);
      check("R8 cycle4 valid", 64'(out_valid), 64'd2);
      check("R8 cycle4 high", 64'(res_hi), 64'(sc[63:32]));
    end

    // R9: idle cycles with moving operands leave the sum alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      req_op = 3'(k); req_a = 32'hA5A5A5A5 ^ 32'(k); req_b = 32'h5A5A5A5A + 32'(k);
    end
    do_op(3'b100, 32'd0, 32'd0, "R9 idle hold");
    do_op(3'b101, 32'd0, 32'd0, "R9 idle hold");

    // R1: reset in mid-run clears the sum and valids
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'b100; req_a = 32'd5; req_b = 32'd9;
    rst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 mid-run valid", 64'(out_valid), 64'd0);
    rst = 1'b0;
    macc = '0;
    do_op(3'b101, 32'd0, 32'd0, "R1 cleared");
    do_op(3'b100, 32'd0, 32'd0, "R1 cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(100000 * 5ns);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule